// File: doc/BRIEF.md
# Pipelined Sigmoid from Hyperbolic Sine and Cosine

This block computes the logistic sigmoid of a neural-network pre-activation without multipliers. A small front stage clamps the raw pre-activation to the interval [-1, 1] and halves it. The halved argument goes to an external hyperbolic rotator, which returns a cosh/sinh pair for that argument. The main datapath then divides sinh by cosh using shift-add linear vectoring iterations, one per pipeline stage. Each stage pushes the residual toward zero and adds the quotient into an accumulator. The resulting tanh value is halved and offset by one half to give the sigmoid.

The block accepts one pair per clock cycle, gaps allowed, and returns one sigmoid word per accepted pair after a fixed latency. Formats: pre-activation and argument are signed Q3.12, cosh and sinh are signed Q2.14, and the sigmoid output is unsigned Q0.16, so 0x8000 means 0.5.

Top module: `sigmoid_lvc_pipe`

## Requirements
- R1: The front stage clamps the pre-activation to [-4096, 4096] (±1.0 in Q3.12) and outputs the clamped value arithmetically shifted right by one bit on `arg_half`. The result therefore lies in [-2048, 2048], and -1 maps to -1.
- R2: `arg_valid` is `preact_valid` delayed by exactly one clock cycle.
- R3: A pair accepted with `rot_valid` high yields `sig_valid` high exactly 18 cycles later. Back-to-back pairs give back-to-back results in input order.
- R4: For a pair (cosh(a), sinh(a)) in Q2.14 with |a| ≤ 0.5, `sig_out`/65536 is within 8/65536 of 0.5·(1 + tanh(a)).
- R5: A pair with sinh equal to zero yields exactly 0x8000 (0.5).
- R6: Every valid `sig_out` lies in [0x4000, 0xC000]. The internal quotient stays below 0.5 in magnitude.
- R7: A positive sinh yields `sig_out` ≥ 0x8000, and a negative sinh yields `sig_out` ≤ 0x8000.
- R8: Over a dense sweep of arguments in [-0.5, 0.5], the mean absolute error against 0.5·(1 + tanh(a)) is below 5e-4.
- R9: While `rst_n` is low, and in the cycle after it, `sig_valid` and `arg_valid` are low and `sig_out` and `arg_half` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preact_valid | input | 1 | Pre-activation qualifier |
| preact | input | 16 | Raw pre-activation, signed Q3.12 |
| arg_valid | output | 1 | Halved argument qualifier |
| arg_half | output | 16 | Clamped and halved argument, signed Q3.12 |
| rot_valid | input | 1 | cosh/sinh pair qualifier |
| rot_cosh | input | 16 | Hyperbolic cosine, signed Q2.14 |
| rot_sinh | input | 16 | Hyperbolic sine, signed Q2.14 |
| sig_valid | output | 1 | Sigmoid result qualifier |
| sig_out | output | 16 | Sigmoid, unsigned Q0.16 |

## Verification
The front stage is tested with values just inside, on, and beyond both clamp bounds, and with small negative odd values. These cases distinguish a correct clamp and arithmetic shift from an off-by-one bound or a logical shift. The divider is driven three ways: a dense ordered sweep of arguments, which measures the mean error; random arguments with random idle gaps, which expose valid misalignment and latency errors; and a zero sinh, which shows whether the final rounding lands exactly on one half. Sign checks on positive and negative arguments distinguish a wrong direction decision from a mere loss of precision.

// File: rtl/sigmoid_lvc_pipe.sv
module sigmoid_lvc_pipe #(
  parameter int W        = 16,
  parameter int N_ITER   = 16,
  parameter int GUARD    = 4,
  parameter int PRE_FRAC = 12,
  parameter int Q_FRAC   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                preact_valid,
  input  logic signed [W-1:0] preact,
  output logic                arg_valid,
  output logic signed [W-1:0] arg_half,
  input  logic                rot_valid,
  input  logic signed [W-1:0] rot_cosh,
  input  logic signed [W-1:0] rot_sinh,
  output logic                sig_valid,
  output logic        [W-1:0] sig_out
);

  localparam int IW = W + GUARD + 1;
  localparam int ZW = Q_FRAC + 3;
  localparam logic signed [W-1:0] ONE_S = W'(1 << PRE_FRAC);
  localparam logic signed [W-1:0] HALF_ARG = W'(1 << (PRE_FRAC - 1));
  localparam logic signed [ZW-1:0] HALF_Z = ZW'(1 << (Q_FRAC - 1));
  localparam logic signed [ZW-1:0] SIG_HALF = ZW'(1 << (W - 1));
  localparam logic signed [ZW-1:0] SIG_LO = ZW'(1 << (W - 2));
  localparam logic signed [ZW-1:0] SIG_HI = ZW'(3 << (W - 2));

  // front stage: clamp then halve
  logic signed [W-1:0] pre_sat;
  assign pre_sat = (preact > ONE_S) ? ONE_S : ((preact < -ONE_S) ? -ONE_S : preact);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_valid <= 1'b0;
      arg_half  <= '0;
    end else begin
      arg_valid <= preact_valid;
      if (preact_valid) arg_half <= pre_sat >>> 1;
    end
  end

  assert_arg_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arg_valid |-> (arg_half <= HALF_ARG && arg_half >= -HALF_ARG));
  assert_arg_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    preact_valid |=> arg_valid);
  assert_arg_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !preact_valid |=> !arg_valid);

  // linear vectoring divider: y -> 0, z accumulates sinh/cosh
  logic                 v_q [0:N_ITER];
  logic signed [IW-1:0] x_q [0:N_ITER];
  logic signed [IW-1:0] y_q [0:N_ITER];
  logic signed [ZW-1:0] z_q [0:N_ITER];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      x_q[0] <= '0;
      y_q[0] <= '0;
      z_q[0] <= '0;
    end else begin
      v_q[0] <= rot_valid;
      x_q[0] <= {{(IW-W-GUARD){rot_cosh[W-1]}}, rot_cosh, {GUARD{1'b0}}};
      y_q[0] <= {{(IW-W-GUARD){rot_sinh[W-1]}}, rot_sinh, {GUARD{1'b0}}};
      z_q[0] <= '0;
    end
  end

  for (genvar k = 1; k <= N_ITER; k++) begin : g_iter
    localparam logic signed [ZW-1:0] STEP = ZW'(1 << (Q_FRAC - k));
    logic signed [IW-1:0] x_sh;
    assign x_sh = x_q[k-1] >>> k;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[k] <= 1'b0;
        x_q[k] <= '0;
        y_q[k] <= '0;
        z_q[k] <= '0;
      end else begin
        v_q[k] <= v_q[k-1];
        x_q[k] <= x_q[k-1];
        if (y_q[k-1] > 0) begin
          y_q[k] <= y_q[k-1] - x_sh;
          z_q[k] <= z_q[k-1] + STEP;
        end else begin
          y_q[k] <= y_q[k-1] + x_sh;
          z_q[k] <= z_q[k-1] - STEP;
        end
      end
    end
  end

  assert_quot_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_q[N_ITER] |-> (z_q[N_ITER] < HALF_Z && z_q[N_ITER] > -HALF_Z));

  // sigmoid mapping: 0.5 + quotient/2, rounded
  logic signed [ZW-1:0] z_rnd;
  logic signed [ZW-1:0] sig_sum;
  assign z_rnd   = (z_q[N_ITER] + ZW'(1)) >>> 1;
  assign sig_sum = SIG_HALF + z_rnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_valid <= 1'b0;
      sig_out   <= '0;
    end else begin
      sig_valid <= v_q[N_ITER];
      if (v_q[N_ITER]) sig_out <= sig_sum[W-1:0];
    end
  end

  assert_sig_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |-> ({3'b000, sig_out} >= SIG_LO && {3'b000, sig_out} <= SIG_HI));
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!sig_valid && !arg_valid && sig_out == '0 && arg_half == '0));

endmodule

// File: tb/sigmoid_lvc_pipe_tb.sv
module sigmoid_lvc_pipe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic preact_valid = 1'b0;
  logic signed [15:0] preact = '0;
  logic arg_valid;
  logic signed [15:0] arg_half;
  logic rot_valid = 1'b0;
  logic signed [15:0] rot_cosh = '0;
  logic signed [15:0] rot_sinh = '0;
  logic sig_valid;
  logic [15:0] sig_out;

  always #2 clk = ~clk;

  sigmoid_lvc_pipe dut_i (
    .clk(clk), .rst_n(rst_n),
    .preact_valid(preact_valid), .preact(preact),
    .arg_valid(arg_valid), .arg_half(arg_half),
    .rot_valid(rot_valid), .rot_cosh(rot_cosh), .rot_sinh(rot_sinh),
    .sig_valid(sig_valid), .sig_out(sig_out)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  exp_cyc [0:8191];
  real exp_arg [0:8191];
  int  wr_i = 0;
  int  rd_i = 0;
  int  fexp [0:1023];
  int  fwr = 0;
  int  frd = 0;
  real err_sum = 0.0;
  int  err_n = 0;

  function automatic int q14(real v);
    return $rtoi(v * 16384.0 + ((v >= 0.0) ? 0.5 : -0.5));
  endfunction

  function automatic int front_ref(int p);
    int s;
    s = (p > 4096) ? 4096 : ((p < -4096) ? -4096 : p);
    return s >>> 1;
  endfunction

  task automatic check(bit ok, string req, real act, real exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%f expected=%f", req, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && arg_valid) begin
      check(int'(arg_half) == fexp[frd], "R1", real'(arg_half), real'(fexp[frd]));
      frd++;
    end
    if (rst_n && sig_valid) begin
      real a, r, got, e;
      a = exp_arg[rd_i];
      r = 0.5 * (1.0 + $tanh(a));
      got = real'(sig_out) / 65536.0;
      e = (got > r) ? got - r : r - got;
      err_sum += e; err_n++;
      check(cyc - exp_cyc[rd_i] == 18, "R3", real'(cyc - exp_cyc[rd_i]), 18.0);
      check(e <= 8.0 / 65536.0, "R4", got, r);
      if (q14($sinh(a)) == 0) check(sig_out == 16'h8000, "R5", real'(sig_out), 32768.0);
      else if (q14($sinh(a)) > 0) check(sig_out >= 16'h8000, "R7", real'(sig_out), 32768.0);
      else check(sig_out <= 16'h8000, "R7", real'(sig_out), 32768.0);
      rd_i++;
    end
  end

  task automatic send_pre(int p);
    @(negedge clk);
    preact_valid = 1'b1; preact = 16'(p);
    fexp[fwr] = front_ref(p); fwr++;
    @(negedge clk);
    preact_valid = 1'b0;
  endtask

  task automatic send_rot(real a);
    @(negedge clk);
    rot_valid = 1'b1;
    rot_cosh = 16'(q14($cosh(a)));
    rot_sinh = 16'(q14($sinh(a)));
    exp_arg[wr_i] = a; exp_cyc[wr_i] = cyc; wr_i++;
  endtask

  task automatic idle();
    @(negedge clk);
    rot_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!sig_valid && !arg_valid, "R9", real'(sig_valid), 0.0);
    check(sig_out == 0 && arg_half == 0, "R9", real'(sig_out), 0.0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R2 front stage corners and random
    foreach (fexp[i]) fexp[i] = 0;
    send_pre(32767); send_pre(-32768); send_pre(4096); send_pre(4097);
    send_pre(4095); send_pre(-4096); send_pre(-4097); send_pre(-1);
    send_pre(1); send_pre(0); send_pre(-3);
    for (int i = 0; i < 40; i++) send_pre(int'($urandom % 65536) - 32768);
    // R2: arg_valid tracks preact_valid one cycle later
    @(negedge clk); preact_valid = 1'b1; preact = 16'd100; fexp[fwr] = 50; fwr++;
    @(posedge clk); #1;
    check(arg_valid == 1'b1, "R2", real'(arg_valid), 1.0);
    @(negedge clk); preact_valid = 1'b0;
    @(posedge clk); #1;
    check(arg_valid == 1'b0, "R2", real'(arg_valid), 0.0);

    // R5 zero, then R8 dense ordered sweep back-to-back
    send_rot(0.0); idle();
    for (int n = -2048; n <= 2048; n += 4) send_rot(real'(n) / 4096.0);
    idle();
    // random arguments with gaps (R3/R4/R7)
    for (int i = 0; i < 2000; i++) begin
      send_rot(real'(int'($urandom % 4097) - 2048) / 4096.0);
      if ($urandom % 4 == 0) idle();
    end
    send_rot(0.5); send_rot(-0.5); send_rot(0.0);
    idle();
    repeat (30) @(negedge clk);
    check(rd_i == wr_i, "R3", real'(rd_i), real'(wr_i));
    check(frd == fwr, "R2", real'(frd), real'(fwr));
    check(err_n > 0 && err_sum / real'(err_n) < 5.0e-4, "R8",
          (err_n > 0) ? err_sum / real'(err_n) : 1.0, 5.0e-4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule